// File: doc/BRIEF.md
# 4x4 Inverse Transform Reconstruction Unit

This unit rebuilds one 4x4 block of 8-bit pixels from sixteen signed 16-bit coefficients and a 4x4 block of prediction pixels. Both inputs arrive together in one handshake beat. The coefficients pass through a one-dimensional inverse butterfly applied to each row. The intermediate matrix is then transposed, and the same butterfly is applied to each column. Each result is scaled down by 64 with rounding, added to its prediction pixel, and clamped to the 8-bit unsigned range.

The block sits after dequantisation in a video reconstruction path. A producer presents a block with `in_valid` and waits for `in_ready`. Two clock edges after acceptance, the finished pixels appear on `pix_out`, marked by a one-cycle `out_valid` pulse. No new block is taken while one is in flight or being presented.

Top module: `inv4x4_recon`

## Requirements
- R1: Synchronous reset drives `out_valid` low and `in_ready` high from the first clock edge after reset.
- R2: Each one-dimensional pass on inputs a, b, c, d first forms e0=a+c, e1=a-c, e2=(b>>>1)-d and e3=b+(d>>>1), where >>> is an arithmetic right shift.
- R3: Each pass then outputs f0=e0+e3, f1=e1+e2, f2=e1-e2 and f3=e0-e3, in that order.
- R4: The pass is first applied to each row, taking a..d as columns 0..3. It is then applied to each column of the row results, taking a..d as rows 0..3, and output k of column c becomes pixel (row k, column c). Coefficient (row r, column c) is carried in `coef_in[16*(4r+c) +: 16]`.
- R5: All butterfly sums and differences are 16-bit two's complement and wrap on overflow.
- R6: Each final transform value v is reduced to (v+32)>>>6, computed without overflow.
- R7: The reduced value is added to the zero-extended prediction pixel. The sum is clamped to 0 when negative and to 255 when above 255. Prediction pixel (r,c) is carried in `pred_in[8*(4r+c) +: 8]`.
- R8: A block whose sixteen coefficients are all zero reproduces its prediction block exactly.
- R9: After a block is accepted, `in_ready` stays low until the edge that follows the `out_valid` pulse. `in_valid` and the input data are ignored while `in_ready` is low.
- R10: `out_valid` is a single-cycle pulse, asserted exactly two clock edges after the accepting edge. It carries pixel (r,c) in `pix_out[8*(4r+c) +: 8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Unit can accept a block |
| coef_in | input | 256 | Sixteen signed coefficients, row-major |
| pred_in | input | 128 | Sixteen prediction pixels, row-major |
| out_valid | output | 1 | One-cycle marker of a finished block |
| pix_out | output | 128 | Sixteen reconstructed pixels, row-major |

## Verification
The bound checker watches the handshake on every cycle. It checks that `in_ready` drops after acceptance and returns after the output pulse, that `out_valid` is one cycle wide and lands two edges after acceptance, and that an all-zero coefficient block reproduces its prediction. The arithmetic can only be shown by the bench's scenarios, which compare each output against an independent model. These scenarios cover the rounding boundaries at plus and minus one half, clamping at both ends of the pixel range, 16-bit wrap, the odd-term halving of negative values, the transpose order using single-coefficient blocks, and data offered while the unit is busy.

// File: rtl/recon_pkg.sv
package recon_pkg;

    // Geometry and precision
    localparam int DIM       = 4;
    localparam int NCOEF     = DIM * DIM;
    localparam int COEF_W    = 16;
    localparam int PIX_W     = 8;
    localparam int RND_SHIFT = 6;

    // Derived constants
    localparam int COEF_BUS_W = NCOEF * COEF_W;
    localparam int PIX_BUS_W  = NCOEF * PIX_W;
    localparam int PIX_MAX    = (1 << PIX_W) - 1;
    localparam int EXT_W      = COEF_W + 1;
    localparam int SUM_W      = COEF_W + 2;
    localparam logic signed [EXT_W-1:0] RND_BIAS = EXT_W'(1 << (RND_SHIFT - 1));

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [PIX_W-1:0]         pix_t;
    typedef coef_t                    quad_t [DIM];

    // Sequencing states of the handshake controller
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COL  = 2'd1,
        ST_OUT  = 2'd2
    } rc_state_e;

    // Intermediate values of one butterfly pass
    typedef struct packed {
        coef_t even_sum;
        coef_t even_dif;
        coef_t odd_dif;
        coef_t odd_sum;
    } bfly_mid_t;

    // Rounded down-scale, prediction add and unsigned clamp
    function automatic pix_t recon_pixel(input coef_t v, input pix_t p);
        logic signed [EXT_W-1:0] ext;
        logic signed [EXT_W-1:0] rnd;
        logic signed [SUM_W-1:0] tot;
        ext = {v[COEF_W-1], v};
        rnd = (ext + RND_BIAS) >>> RND_SHIFT;
        tot = $signed({rnd[EXT_W-1], rnd}) + $signed({{(SUM_W-PIX_W){1'b0}}, p});
        if (tot < 0)
            return '0;
        else if (tot > PIX_MAX)
            return pix_t'(PIX_MAX);
        else
            return tot[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/rc_butterfly.sv
module rc_butterfly
    import recon_pkg::*;
(
    input  quad_t x,
    output quad_t y
);

    bfly_mid_t mid;

    // First level: even pair and half-weighted odd pair
    always_comb begin
        mid.even_sum = x[0] + x[2];
        mid.even_dif = x[0] - x[2];
        mid.odd_dif  = (x[1] >>> 1) - x[3];
        mid.odd_sum  = x[1] + (x[3] >>> 1);
    end

    // Second level: combine
    always_comb begin
        y[0] = mid.even_sum + mid.odd_sum;
        y[1] = mid.even_dif + mid.odd_dif;
        y[2] = mid.even_dif - mid.odd_dif;
        y[3] = mid.even_sum - mid.odd_sum;
    end

endmodule

// File: rtl/rc_recon_lane.sv
module rc_recon_lane
    import recon_pkg::*;
(
    input  coef_t res_val,
    input  pix_t  pred_pix,
    output pix_t  rec_pix
);

    assign rec_pix = recon_pixel(res_val, pred_pix);

endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
    import recon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    output logic load_mid,
    output logic load_out,
    output logic out_valid
);

    rc_state_e state_q;
    rc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_COL;
            ST_COL:  state_d = ST_OUT;
            ST_OUT:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign load_mid  = in_ready && in_valid;
    assign load_out  = (state_q == ST_COL);
    assign out_valid = (state_q == ST_OUT);

endmodule

// File: rtl/inv4x4_recon.sv
module inv4x4_recon
    import recon_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [COEF_BUS_W-1:0] coef_in,
    input  logic [PIX_BUS_W-1:0]  pred_in,
    output logic                  out_valid,
    output logic [PIX_BUS_W-1:0]  pix_out
);

    logic load_mid;
    logic load_out;

    quad_t                coef_grid [DIM];
    quad_t                row_res   [DIM];
    quad_t                mid_q     [DIM];
    quad_t                col_res   [DIM];
    logic [PIX_BUS_W-1:0] pred_q;
    pix_t                 rec_pix   [NCOEF];
    logic [PIX_BUS_W-1:0] pix_q;

    rc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .load_mid  (load_mid),
        .load_out  (load_out),
        .out_valid (out_valid)
    );

    // Unpack the row-major coefficient bus
    always_comb begin
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++)
                coef_grid[r][c] = coef_in[(r*DIM + c)*COEF_W +: COEF_W];
    end

    // Row pass
    for (genvar r = 0; r < DIM; r++) begin : g_row
        rc_butterfly u_row (
            .x (coef_grid[r]),
            .y (row_res[r])
        );
    end

    // Stage register stores the row results transposed
    always_ff @(posedge clk) begin
        if (load_mid) begin
            for (int r = 0; r < DIM; r++)
                for (int c = 0; c < DIM; c++)
                    mid_q[c][r] <= row_res[r][c];
            pred_q <= pred_in;
        end
    end

    // Column pass: entry c of mid_q holds column c top to bottom
    for (genvar c = 0; c < DIM; c++) begin : g_col
        rc_butterfly u_col (
            .x (mid_q[c]),
            .y (col_res[c])
        );
    end

    // Per-pixel rounding, prediction add and clamp
    for (genvar i = 0; i < NCOEF; i++) begin : g_lane
        localparam int ROW = i / DIM;
        localparam int COL = i % DIM;
        rc_recon_lane u_lane (
            .res_val  (col_res[COL][ROW]),
            .pred_pix (pred_q[i*PIX_W +: PIX_W]),
            .rec_pix  (rec_pix[i])
        );
    end

    always_ff @(posedge clk) begin
        if (load_out) begin
            for (int i = 0; i < NCOEF; i++)
                pix_q[i*PIX_W +: PIX_W] <= rec_pix[i];
        end
    end

    assign pix_out = pix_q;

endmodule

// File: rtl/rc_checker.sv
module rc_checker
    import recon_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [COEF_BUS_W-1:0] coef_in,
    input logic [PIX_BUS_W-1:0]  pred_in,
    input logic                  out_valid,
    input logic [PIX_BUS_W-1:0]  pix_out
);

    logic                 zero_blk_q;
    logic [PIX_BUS_W-1:0] pred_cap_q;

    // Remember, per accepted block, whether it was all zero and its prediction
    always_ff @(posedge clk) begin
        if (rst) begin
            zero_blk_q <= 1'b0;
            pred_cap_q <= '0;
        end else if (in_valid && in_ready) begin
            zero_blk_q <= (coef_in == '0);
            pred_cap_q <= pred_in;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_ready_after_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> in_ready);

    assert_no_ready_during_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ##1 out_valid);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_pulse_has_source_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_ready, 2));

    assert_zero_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zero_blk_q) |-> (pix_out == pred_cap_q));

endmodule

bind inv4x4_recon rc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .coef_in   (coef_in),
    .pred_in   (pred_in),
    .out_valid (out_valid),
    .pix_out   (pix_out)
);

// File: tb/inv4x4_recon_test.sv
`timescale 1ns/1ps
module inv4x4_recon_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] coef_in = '0;
    logic [127:0] pred_in = '0;
    logic         out_valid;
    logic [127:0] pix_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;   // 250 MHz

    inv4x4_recon uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .coef_in   (coef_in),
        .pred_in   (pred_in),
        .out_valid (out_valid),
        .pix_out   (pix_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int w16(input int x);
        logic signed [15:0] t;
        t = x[15:0];
        return int'(t);
    endfunction

    function automatic void bfly(input int a, input int b, input int c, input int d,
                                 output int f0, output int f1, output int f2, output int f3);
        int e0, e1, e2, e3;
        e0 = w16(a + c);
        e1 = w16(a - c);
        e2 = w16((b >>> 1) - d);
        e3 = w16(b + (d >>> 1));
        f0 = w16(e0 + e3);
        f1 = w16(e1 + e2);
        f2 = w16(e1 - e2);
        f3 = w16(e0 - e3);
    endfunction

    function automatic logic [127:0] model(input logic [255:0] cf, input logic [127:0] pr);
        int g [4][4];
        int t [4][4];
        int o [4][4];
        logic [127:0] res;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                g[r][c] = w16(int'(cf[(r*4+c)*16 +: 16]));
        for (int r = 0; r < 4; r++)
            bfly(g[r][0], g[r][1], g[r][2], g[r][3], t[r][0], t[r][1], t[r][2], t[r][3]);
        for (int c = 0; c < 4; c++)
            bfly(t[0][c], t[1][c], t[2][c], t[3][c], o[0][c], o[1][c], o[2][c], o[3][c]);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                int s;
                s = ((o[r][c] + 32) >>> 6) + int'(pr[(r*4+c)*8 +: 8]);
                if (s < 0) s = 0;
                if (s > 255) s = 255;
                res[(r*4+c)*8 +: 8] = s[7:0];
            end
        return res;
    endfunction

    function automatic logic [255:0] dc_block(input int v);
        logic [255:0] cf;
        cf = '0;
        cf[15:0] = v[15:0];
        return cf;
    endfunction

    function automatic logic [127:0] flat_pred(input int p);
        logic [127:0] pr;
        for (int i = 0; i < 16; i++) pr[i*8 +: 8] = p[7:0];
        return pr;
    endfunction

    task automatic next_rand(output logic [31:0] v);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        v = lfsr ^ {lfsr[15:0], lfsr[31:16]};
    endtask

    // Send one block, check handshake timing and output; returns the pixels seen
    task automatic run_block(input logic [255:0] cf, input logic [127:0] pr,
                             input string req, output logic [127:0] got);
        logic [127:0] exp;
        exp = model(cf, pr);
        @(negedge clk);
        check(in_ready === 1'b1, "R9", "ready before send", {127'd0, in_ready}, 128'd1);
        coef_in  = cf;
        pred_in  = pr;
        in_valid = 1'b1;
        @(posedge clk);
        #0.5 in_valid = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b0 && out_valid === 1'b0, "R9", "busy after accept",
              {126'd0, in_ready, out_valid}, 128'd0);
        @(negedge clk);
        check(out_valid === 1'b1, "R10", "pulse two edges after accept",
              {127'd0, out_valid}, 128'd1);
        check(pix_out === exp, req, "pixels", pix_out, exp);
        got = pix_out;
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R10", "pulse ends, ready back",
              {126'd0, out_valid, in_ready}, 128'd1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "out_valid in reset", {127'd0, out_valid}, 128'd0);
        check(in_ready === 1'b1, "R1", "in_ready in reset", {127'd0, in_ready}, 128'd1);
    endtask

    task automatic t_zero;
        logic [127:0] pr, got;
        for (int i = 0; i < 16; i++) pr[i*8 +: 8] = 8'(i * 17 + 3);
        run_block('0, pr, "R8", got);
        check(got === pr, "R8", "zero block keeps prediction", got, pr);
        run_block('0, flat_pred(255), "R8", got);
        check(got === flat_pred(255), "R8", "zero block top value", got, flat_pred(255));
    endtask

    task automatic t_round;
        logic [127:0] got;
        run_block(dc_block(31), flat_pred(100), "R6", got);
        check(got[7:0] === 8'd100, "R6", "31 rounds to 0", {120'd0, got[7:0]}, 128'd100);
        run_block(dc_block(32), flat_pred(100), "R6", got);
        check(got[7:0] === 8'd101, "R6", "32 rounds to 1", {120'd0, got[7:0]}, 128'd101);
        run_block(dc_block(-32), flat_pred(100), "R6", got);
        check(got[7:0] === 8'd100, "R6", "-32 rounds to 0", {120'd0, got[7:0]}, 128'd100);
        run_block(dc_block(-33), flat_pred(100), "R6", got);
        check(got[7:0] === 8'd99, "R6", "-33 rounds to -1", {120'd0, got[7:0]}, 128'd99);
    endtask

    task automatic t_saturate;
        logic [127:0] got;
        run_block(dc_block(32000), flat_pred(200), "R7", got);
        check(got === flat_pred(255), "R7", "clamp high", got, flat_pred(255));
        run_block(dc_block(-32000), flat_pred(50), "R7", got);
        check(got === flat_pred(0), "R7", "clamp low", got, flat_pred(0));
        run_block(dc_block(55 * 64), flat_pred(200), "R7", got);
        check(got === flat_pred(255), "R7", "exactly 255", got, flat_pred(255));
        run_block(dc_block(-64 * 10), flat_pred(10), "R7", got);
        check(got === flat_pred(0), "R7", "exactly 0", got, flat_pred(0));
    endtask

    // One nonzero coefficient at each position exposes pass order and layout
    task automatic t_positions;
        logic [127:0] got;
        for (int k = 0; k < 16; k++) begin
            logic [255:0] cf;
            cf = '0;
            cf[k*16 +: 16] = (k % 2 == 0) ? 16'sd1000 : -16'sd1000;
            run_block(cf, flat_pred(128), "R4", got);
        end
    endtask

    // Odd negative values check the arithmetic halving of odd terms
    task automatic t_odd_terms;
        logic [127:0] got;
        logic [255:0] cf;
        cf = '0;
        cf[1*16 +: 16] = -16'sd67;
        cf[3*16 +: 16] = -16'sd129;
        cf[13*16 +: 16] = 16'sd99;
        cf[7*16 +: 16] = -16'sd1;
        run_block(cf, flat_pred(128), "R2", got);
        cf = '0;
        cf[0 +: 16] = 16'sd500;
        cf[2*16 +: 16] = -16'sd300;
        cf[8*16 +: 16] = 16'sd77;
        cf[10*16 +: 16] = -16'sd45;
        run_block(cf, flat_pred(90), "R3", got);
    endtask

    task automatic t_wrap;
        logic [127:0] got;
        logic [255:0] cf;
        for (int i = 0; i < 16; i++) cf[i*16 +: 16] = (i % 3 == 0) ? 16'sd30000 : -16'sd29000;
        run_block(cf, flat_pred(128), "R5", got);
        for (int i = 0; i < 16; i++) cf[i*16 +: 16] = 16'h7FFF;
        run_block(cf, flat_pred(7), "R5", got);
    endtask

    task automatic t_random;
        logic [127:0] got;
        for (int n = 0; n < 24; n++) begin
            logic [255:0] cf;
            logic [127:0] pr;
            logic [31:0]  v;
            for (int i = 0; i < 16; i++) begin
                next_rand(v);
                cf[i*16 +: 16] = (n < 12) ? {{6{v[9]}}, v[9:0]} : v[15:0];
                pr[i*8 +: 8] = v[23:16];
            end
            run_block(cf, pr, "R7", got);
        end
    endtask

    // Data offered while busy must neither change nor repeat the output
    task automatic t_ignore_busy;
        logic [255:0] cf_a, cf_b;
        logic [127:0] pr_a, pr_b, exp_a;
        for (int i = 0; i < 16; i++) begin
            cf_a[i*16 +: 16] = 16'(i * 40 - 300);
            cf_b[i*16 +: 16] = 16'(5000 - i * 700);
            pr_a[i*8 +: 8] = 8'(i * 9);
            pr_b[i*8 +: 8] = 8'(250 - i);
        end
        exp_a = model(cf_a, pr_a);
        @(negedge clk);
        coef_in = cf_a; pred_in = pr_a; in_valid = 1'b1;
        @(posedge clk);
        #0.5 coef_in = cf_b; pred_in = pr_b;
        @(negedge clk);
        check(in_ready === 1'b0, "R9", "busy with input held", {127'd0, in_ready}, 128'd0);
        @(negedge clk);
        check(out_valid === 1'b1 && pix_out === exp_a, "R9", "busy input ignored", pix_out, exp_a);
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R9", "no pulse for ignored block", {127'd0, out_valid}, 128'd0);
        end
        check(pix_out === exp_a, "R9", "output held", pix_out, exp_a);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        t_reset;
        @(negedge clk);
        rst = 1'b0;
        t_zero;
        t_round;
        t_saturate;
        t_positions;
        t_odd_terms;
        t_wrap;
        t_random;
        t_ignore_busy;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule